// File: doc/BRIEF.md
# Dual-Line Interrupt Cause Controller

This block collects up to 32 hardware event requests into one sticky cause register and qualifies them with one shared unmask register. From the qualified pending set it drives two independent level-sensitive interrupt lines. The legacy line covers a fixed group of four event bits (24 to 27). The error line covers every other bit. Each event source raises its bit with a single-cycle request pulse. The bit then stays set until software writes a 1 to that exact bit position in the cause register.

Two interrupt handlers can share the register pair without disturbing each other. Each handler clears only the bits it owns. The other line keeps signalling for as long as any of its own unmasked bits is still pending. A partial clear therefore leaves the line raised, and the interrupt is signalled again.

Software reaches both registers through a plain synchronous port: select strobe, write enable, word address and write data. Read data is registered.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, the cause register and the unmask register both read as zero, and both interrupt lines are low.
- R2: A 1 on bit i of `evt_req` at a clock edge sets cause bit i. The bit stays set across any number of cycles and reads until software clears it.
- R3: A read of the cause register (word address 0) returns the value the register held before that edge, in `reg_rdata` after the edge. The read changes no cause bit.
- R4: A write to the cause register clears exactly the bits whose write-data bit is 1. Write-data bits that are 0 leave their cause bits unchanged, in either group.
- R5: When an event request and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: A write to the unmask register (word address 1) replaces all 32 bits. A read of address 1 returns the stored value. The unmask register changes only on such a write.
- R7: `irq_legacy` is high exactly when some bit in 24..27 is set in both the cause and the unmask register.
- R8: `irq_error` is high exactly when some bit outside 24..27 is set in both the cause and the unmask register. Bits 24..27 never raise it.
- R9: A pending bit whose unmask bit is 0 keeps its cause bit set, but it raises neither line. After a partial clear, a line whose group still holds an unmasked pending bit stays high.
- R10: A read of any word address other than 0 and 1 returns zero. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_req | input | 32 | Per-bit event request pulses |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read, when `reg_sel` is high |
| reg_addr | input | 4 | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data; holds between reads |
| irq_legacy | output | 1 | Level interrupt for event bits 24..27 |
| irq_error | output | 1 | Level interrupt for all other event bits |

## Verification
A corrupted cause bit appears at the ports in one of two ways. It can toggle an interrupt line in the cycle after the faulty edge, if its unmask bit is set. Otherwise it shows in the next read of address 0, one edge after that read is issued. Because the bit is sticky, the error stays visible until software clears it. A wrong group boundary or wrong unmask contents shows on a line at once, when single bits at positions 23, 24, 27 and 28 are made pending one at a time. The same-cycle set/clear case and writes of zero data are driven on purpose. A lost event or an over-broad clear then shows in the read that follows.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Register width and address width of the software port
    localparam int unsigned REG_W   = 32;
    localparam int unsigned ADDR_W  = 4;

    // Word addresses of the two registers
    localparam int unsigned CAUSE_IDX  = 0;
    localparam int unsigned UNMASK_IDX = 1;

    // Legacy interrupt group: a run of LEG_CNT bits starting at LEG_LO
    localparam int unsigned LEG_LO  = 24;
    localparam int unsigned LEG_CNT = 4;

    // Kind of access the port decodes in a given cycle
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cause_o
);

    typedef struct packed {
        logic [W-1:0] cause;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // Clear first, then set: a request in the same cycle as its clear survives
    always_comb begin
        st_d       = st_q;
        st_d.cause = (st_q.cause & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;

endmodule

// File: rtl/irq_regport.sv
module irq_regport #(
    parameter int unsigned W          = 32,
    parameter int unsigned AW         = 4,
    parameter int unsigned CAUSE_IDX  = 0,
    parameter int unsigned UNMASK_IDX = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  cause_i,
    output logic [W-1:0]  unmask_o,
    output logic [W-1:0]  clr_o,
    output logic [W-1:0]  rdata_o
);

    import irq_pkg::*;

    localparam logic [AW-1:0] A_CAUSE  = AW'(CAUSE_IDX);
    localparam logic [AW-1:0] A_UNMASK = AW'(UNMASK_IDX);

    typedef struct packed {
        logic [W-1:0] unmask;
        logic [W-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;
    acc_e     acc;
    logic     hit_cause;
    logic     hit_unmask;

    always_comb begin
        if (!sel_i)     acc = ACC_NONE;
        else if (we_i)  acc = ACC_WRITE;
        else            acc = ACC_READ;
    end

    assign hit_cause  = (addr_i == A_CAUSE);
    assign hit_unmask = (addr_i == A_UNMASK);

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        unique case (acc)
            ACC_WRITE: begin
                if (hit_cause)  clr_o       = wdata_i;
                if (hit_unmask) st_d.unmask = wdata_i;
            end
            ACC_READ: begin
                if (hit_cause)       st_d.rdata = cause_i;
                else if (hit_unmask) st_d.rdata = st_q.unmask;
                else                 st_d.rdata = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unmask_o = st_q.unmask;
    assign rdata_o  = st_q.rdata;

endmodule

// File: rtl/irq_line_split.sv
module irq_line_split #(
    parameter int unsigned W   = 32,
    parameter int unsigned LO  = 24,
    parameter int unsigned CNT = 4
) (
    input  logic [W-1:0] cause_i,
    input  logic [W-1:0] unmask_i,
    output logic         legacy_o,
    output logic         error_o
);

    logic [W-1:0] grp;
    logic [W-1:0] pend;

    // Membership of each bit in the legacy group
    for (genvar i = 0; i < W; i++) begin : g_grp
        if (i >= LO && i < LO + CNT) begin : g_in
            assign grp[i] = 1'b1;
        end else begin : g_out
            assign grp[i] = 1'b0;
        end
    end

    assign pend     = cause_i & unmask_i;
    assign legacy_o = |(pend & grp);
    assign error_o  = |(pend & ~grp);

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
    parameter int unsigned W          = irq_pkg::REG_W,
    parameter int unsigned AW         = irq_pkg::ADDR_W,
    parameter int unsigned CAUSE_IDX  = irq_pkg::CAUSE_IDX,
    parameter int unsigned UNMASK_IDX = irq_pkg::UNMASK_IDX,
    parameter int unsigned LEG_LO     = irq_pkg::LEG_LO,
    parameter int unsigned LEG_CNT    = irq_pkg::LEG_CNT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  evt_req,
    input  logic          reg_sel,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic          irq_legacy,
    output logic          irq_error
);

    logic [W-1:0] cause_w;
    logic [W-1:0] unmask_w;
    logic [W-1:0] clr_w;

    irq_cause_bank #(.W(W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_req),
        .clr_i   (clr_w),
        .cause_o (cause_w)
    );

    irq_regport #(
        .W          (W),
        .AW         (AW),
        .CAUSE_IDX  (CAUSE_IDX),
        .UNMASK_IDX (UNMASK_IDX)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (reg_sel),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .cause_i  (cause_w),
        .unmask_o (unmask_w),
        .clr_o    (clr_w),
        .rdata_o  (reg_rdata)
    );

    irq_line_split #(
        .W   (W),
        .LO  (LEG_LO),
        .CNT (LEG_CNT)
    ) u_split (
        .cause_i  (cause_w),
        .unmask_i (unmask_w),
        .legacy_o (irq_legacy),
        .error_o  (irq_error)
    );

endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk #(
    parameter int unsigned W          = 32,
    parameter int unsigned AW         = 4,
    parameter int unsigned CAUSE_IDX  = 0,
    parameter int unsigned UNMASK_IDX = 1,
    parameter int unsigned LEG_LO     = 24,
    parameter int unsigned LEG_CNT    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  evt_req,
    input logic          reg_sel,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [W-1:0]  reg_wdata,
    input logic [W-1:0]  reg_rdata,
    input logic          irq_legacy,
    input logic          irq_error,
    input logic [W-1:0]  cause_q,
    input logic [W-1:0]  unmask_q
);

    localparam logic [W-1:0]  LEG_M    = ((W'(1) << LEG_CNT) - W'(1)) << LEG_LO;
    localparam logic [AW-1:0] A_CAUSE  = AW'(CAUSE_IDX);
    localparam logic [AW-1:0] A_UNMASK = AW'(UNMASK_IDX);

    logic         wr_cause, wr_unmask, rd_cause, rd_other;
    logic [W-1:0] wr_clr;

    assign wr_cause  = reg_sel && reg_we && (reg_addr == A_CAUSE);
    assign wr_unmask = reg_sel && reg_we && (reg_addr == A_UNMASK);
    assign rd_cause  = reg_sel && !reg_we && (reg_addr == A_CAUSE);
    assign rd_other  = reg_sel && !reg_we && (reg_addr != A_CAUSE) && (reg_addr != A_UNMASK);
    assign wr_clr    = wr_cause ? reg_wdata : '0;

    // R2 and R5: a requested bit is set after the edge, whatever the clear
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(evt_req)) == $past(evt_req)));

    // R4: a set bit drops only where a 1 was written to it
    assert_only_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cause_q) & ~cause_q & ~$past(wr_clr)) == '0));

    // R4: a written 1 with no competing request leaves the bit clear
    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(wr_clr) & ~$past(evt_req)) == '0));

    // R3: a cause read returns the pre-edge value
    assert_read_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cause |=> (reg_rdata == $past(cause_q)));

    // R6: unmask takes the full written word
    assert_unmask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmask |=> (unmask_q == $past(reg_wdata)));

    // R6 and R10: otherwise unmask holds
    assert_unmask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_unmask |=> $stable(unmask_q));

    // R7: legacy line follows its group
    assert_legacy_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (irq_legacy == ((cause_q & unmask_q & LEG_M) != '0)));

    // R8: error line follows all other bits
    assert_error_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (irq_error == ((cause_q & unmask_q & ~LEG_M) != '0)));

    // R10: unmapped reads return zero
    assert_blank_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |=> (reg_rdata == '0));

endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk #(
    .W          (W),
    .AW         (AW),
    .CAUSE_IDX  (CAUSE_IDX),
    .UNMASK_IDX (UNMASK_IDX),
    .LEG_LO     (LEG_LO),
    .LEG_CNT    (LEG_CNT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_req    (evt_req),
    .reg_sel    (reg_sel),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_legacy (irq_legacy),
    .irq_error  (irq_error),
    .cause_q    (cause_w),
    .unmask_q   (unmask_w)
);

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_ctrl;

    localparam int unsigned OP_NONE = 0;
    localparam int unsigned OP_WC   = 1;  // write addr 0 (cause)
    localparam int unsigned OP_WM   = 2;  // write addr 1 (unmask)
    localparam int unsigned OP_RD   = 3;  // read at addr
    localparam int unsigned OP_WX   = 4;  // write at addr

    typedef struct packed {
        logic [31:0] evt;
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic        leg;
        logic        err;
        logic        chk_rd;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{32'h0,         3'd2, 4'd1, 32'h0F01_0000, 1'b0, 1'b0, 1'b0, 32'h0},
        '{32'h0103_0000, 3'd0, 4'd0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0},
        '{32'h0,         3'd3, 4'd0, 32'h0,         1'b1, 1'b1, 1'b1, 32'h0103_0000},
        '{32'h0,         3'd3, 4'd0, 32'h0,         1'b1, 1'b1, 1'b1, 32'h0103_0000},
        '{32'h0,         3'd1, 4'd0, 32'h0001_0000, 1'b1, 1'b0, 1'b0, 32'h0},
        '{32'h0,         3'd3, 4'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0102_0000},
        '{32'h0,         3'd2, 4'd1, 32'h0F02_0000, 1'b1, 1'b1, 1'b0, 32'h0},
        '{32'h0,         3'd1, 4'd0, 32'h0100_0000, 1'b0, 1'b1, 1'b0, 32'h0},
        '{32'h0,         3'd1, 4'd0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0},
        '{32'h0,         3'd3, 4'd1, 32'h0,         1'b0, 1'b1, 1'b1, 32'h0F02_0000},
        '{32'h0,         3'd3, 4'd5, 32'h0,         1'b0, 1'b1, 1'b1, 32'h0},
        '{32'h0,         3'd4, 4'd5, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 32'h0},
        '{32'h0,         3'd3, 4'd0, 32'h0,         1'b0, 1'b1, 1'b1, 32'h0002_0000},
        '{32'h0800_0000, 3'd1, 4'd0, 32'h0802_0000, 1'b1, 1'b0, 1'b0, 32'h0},
        '{32'h0,         3'd3, 4'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0800_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_req = '0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_legacy;
    logic        irq_error;

    int total = 0;
    int bad   = 0;
    logic [31:0] rd_v;

    always #2.5 clk = ~clk;

    dual_irq_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_req    (evt_req),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_legacy (irq_legacy),
        .irq_error  (irq_error)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a negedge, let the edge pass, sample 1 ns later
    task automatic cyc(input logic [31:0] e, input int unsigned op,
                       input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        evt_req   = e;
        reg_sel   = (op != OP_NONE);
        reg_we    = (op == OP_WC) || (op == OP_WM) || (op == OP_WX);
        reg_addr  = (op == OP_WC) ? 4'd0 : (op == OP_WM) ? 4'd1 : a;
        reg_wdata = d;
        @(posedge clk);
        #1;
        evt_req = '0; reg_sel = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        cyc('0, OP_RD, a, '0);
        v = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog all requirements actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state
        chk({31'b0, irq_legacy}, 32'h0, "R1 legacy after reset");
        chk({31'b0, irq_error},  32'h0, "R1 error after reset");
        rd(4'd0, rd_v); chk(rd_v, 32'h0, "R1 cause after reset");
        rd(4'd1, rd_v); chk(rd_v, 32'h0, "R1 unmask after reset");

        // Table: R2 R3 R4 R5 R6 R7 R8 R9 R10 over a mixed sequence
        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].evt, int'(TBL[i].op), TBL[i].addr, TBL[i].data);
            chk({31'b0, irq_legacy}, {31'b0, TBL[i].leg}, $sformatf("R7 R9 legacy vec %0d", i));
            chk({31'b0, irq_error},  {31'b0, TBL[i].err}, $sformatf("R8 R9 error vec %0d", i));
            if (TBL[i].chk_rd)
                chk(reg_rdata, TBL[i].rd, $sformatf("R3 R4 R5 R6 R10 read vec %0d", i));
        end

        // R2 / R9: masked event stays pending but raises nothing
        do_reset();
        cyc(32'h0000_0008, OP_NONE, 4'd0, '0);
        repeat (5) cyc('0, OP_NONE, 4'd0, '0);
        chk({30'b0, irq_legacy, irq_error}, 32'h0, "R9 masked event no line");
        rd(4'd0, rd_v); chk(rd_v, 32'h0000_0008, "R2 masked event sticky");

        // R7 / R8 boundary bits with everything unmasked
        cyc('0, OP_WM, 4'd1, 32'hFFFF_FFFF);
        cyc('0, OP_WC, 4'd0, 32'hFFFF_FFFF);
        chk({30'b0, irq_legacy, irq_error}, 32'h0, "R4 full clear");
        cyc(32'h0080_0000, OP_NONE, 4'd0, '0);
        chk({30'b0, irq_legacy, irq_error}, 32'h1, "R8 bit 23 error only");
        cyc(32'h0000_0000, OP_WC, 4'd0, 32'h0080_0000);
        cyc(32'h1000_0000, OP_NONE, 4'd0, '0);
        chk({30'b0, irq_legacy, irq_error}, 32'h1, "R8 bit 28 error only");
        cyc(32'h0000_0000, OP_WC, 4'd0, 32'h1000_0000);
        cyc(32'h0100_0000, OP_NONE, 4'd0, '0);
        chk({30'b0, irq_legacy, irq_error}, 32'h2, "R7 bit 24 legacy only");
        cyc(32'h0000_0000, OP_WC, 4'd0, 32'h0100_0000);
        cyc(32'h0800_0000, OP_NONE, 4'd0, '0);
        chk({30'b0, irq_legacy, irq_error}, 32'h2, "R7 bit 27 legacy only");

        // R6: unmask write replaces every bit
        cyc('0, OP_WM, 4'd1, 32'h0000_0001);
        chk({30'b0, irq_legacy, irq_error}, 32'h0, "R6 replaced unmask hides bit 27");
        rd(4'd1, rd_v); chk(rd_v, 32'h0000_0001, "R6 unmask readback");

        // R1: reset mid-run clears both registers
        do_reset();
        rd(4'd0, rd_v); chk(rd_v, 32'h0, "R1 cause cleared by reset");
        rd(4'd1, rd_v); chk(rd_v, 32'h0, "R1 unmask cleared by reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule